// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit processor's execute path. Each cycle it takes the first operand, the already shifted second operand, the shifter's carry-out, a 4-bit operation code, a set-flags bit, a flag that says the destination is the program counter, the current 5-bit processor mode and the current N, Z, C and V flags. It computes one of sixteen data-processing operations and the new flag nibble. It also reports whether the destination register is to be written.

Operations fall into three classes, and each class updates the flags in its own way. Addition-class operations set C from the carry out of the top bit. Subtraction-class operations set C when no borrow occurs. Both of these classes set V on signed overflow. Logical operations take C from the shifter and keep V. The four compare and test operations never write a register and always update the flags. An exception covers a write to the program counter with flags enabled while the processor is in a mode that owns a saved status register. In that case the block requests a copy of the saved status register into the current one and leaves the flags alone. Condition evaluation, the register file and the shifter belong to neighbouring blocks.

All results are registered, so they appear one clock after the inputs that produce them.

Top module: `dp_alu_core`

## Requirements
- R1: The opcode selects the operation as follows. 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV (passes the second operand), 14 BIC (A AND NOT B), 15 MVN (NOT B). The result equals that function of A and B.
- R2: ADD gives A+B, ADC gives A+B+C and CMN computes A+B. When flags update, C is the unsigned carry out of bit 31 and V is signed overflow. The flags nibble is bit 3 N, bit 2 Z, bit 1 C, bit 0 V.
- R3: SUB gives A-B, RSB gives B-A, SBC gives A-B-(NOT C), RSC gives B-A-(NOT C) and CMP computes A-B. When flags update, C is 1 exactly when no unsigned borrow occurs and V is signed overflow.
- R4: For AND, EOR, ORR, MOV, BIC, MVN, TST and TEQ, an update sets C from the shifter carry input and keeps V from the flag input.
- R5: Whenever flags update, N equals result bit 31 and Z is 1 exactly when the 32-bit result is zero.
- R6: TST, TEQ, CMP and CMN never assert the destination write and update the flags even when set-flags is low.
- R7: For the other twelve operations with set-flags low, the flag output equals the flag input.
- R8: Consider an operation that sets flags (set-flags high, or a compare/test) whose destination is the program counter while the mode is neither user (5'b10000) nor system (5'b11111). The restore request is then asserted and the flag output equals the flag input.
- R9: In user or system mode, a flag-setting write to the program counter never asserts the restore request and updates the flags normally.
- R10: Every output is registered: it reflects the inputs sampled at the previous rising edge. A synchronous active-high reset clears all outputs to zero.
- R11: The twelve non-compare operations assert the destination write whatever the set-flags bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Shifted second operand |
| sh_carry_i | input | 1 | Carry-out from the shifter |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Flag update enable |
| dest_pc_i | input | 1 | Destination is the program counter |
| mode_i | input | 5 | Current processor mode |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | New flags {N,Z,C,V} |
| wr_dest_o | output | 1 | Destination register is written |
| restore_o | output | 1 | Copy saved status register into current |

## Verification
Result, flags, destination write and restore request all come out of the same register stage. Each one is therefore due exactly one rising edge after the inputs that produce it. The bench drives a vector on a falling edge and computes the expected values at that point. It compares all four outputs one time unit after the next rising edge. One directed check also reads the outputs between driving and that edge, to confirm they still show the previous vector.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,
        CLS_ADD   = 2'd1,
        CLS_SUB   = 2'd2
    } op_class_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef enum logic [2:0] {
        LF_AND  = 3'd0,
        LF_EOR  = 3'd1,
        LF_ORR  = 3'd2,
        LF_PASS = 3'd3,
        LF_BIC  = 3'd4,
        LF_NOT  = 3'd5
    } logic_fn_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        op_class_e cls;
        logic      swap;
        logic      inv_b;
        cin_sel_e  cin_sel;
        logic_fn_e lfn;
        logic      writes_dest;
        logic      forces_flags;
    } alu_ctl_t;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    function automatic logic mode_owns_saved(input logic [4:0] m);
        return !((m == MODE_USR) || (m == MODE_SYS));
    endfunction

    // Independent classifier used by the checks in the top module.
    function automatic logic code_is_logical(input logic [3:0] c);
        return (c == 4'd0) || (c == 4'd1) || (c == 4'd8) || (c == 4'd9) ||
               (c >= 4'd12);
    endfunction

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] opcode_i,
    output alu_ctl_t   ctl_o
);
    alu_op_e op;
    assign op = alu_op_e'(opcode_i);

    always_comb begin
        ctl_o = '{cls: CLS_LOGIC, swap: 1'b0, inv_b: 1'b0, cin_sel: CIN_ZERO,
                  lfn: LF_AND, writes_dest: 1'b1, forces_flags: 1'b0};
        case (op)
            OP_AND: ctl_o.lfn = LF_AND;
            OP_EOR: ctl_o.lfn = LF_EOR;
            OP_ORR: ctl_o.lfn = LF_ORR;
            OP_MOV: ctl_o.lfn = LF_PASS;
            OP_BIC: ctl_o.lfn = LF_BIC;
            OP_MVN: ctl_o.lfn = LF_NOT;
            OP_TST: begin
                ctl_o.lfn          = LF_AND;
                ctl_o.writes_dest  = 1'b0;
                ctl_o.forces_flags = 1'b1;
            end
            OP_TEQ: begin
                ctl_o.lfn          = LF_EOR;
                ctl_o.writes_dest  = 1'b0;
                ctl_o.forces_flags = 1'b1;
            end
            OP_ADD: ctl_o.cls = CLS_ADD;
            OP_ADC: begin
                ctl_o.cls     = CLS_ADD;
                ctl_o.cin_sel = CIN_FLAG;
            end
            OP_CMN: begin
                ctl_o.cls          = CLS_ADD;
                ctl_o.writes_dest  = 1'b0;
                ctl_o.forces_flags = 1'b1;
            end
            OP_SUB: begin
                ctl_o.cls     = CLS_SUB;
                ctl_o.inv_b   = 1'b1;
                ctl_o.cin_sel = CIN_ONE;
            end
            OP_RSB: begin
                ctl_o.cls     = CLS_SUB;
                ctl_o.swap    = 1'b1;
                ctl_o.inv_b   = 1'b1;
                ctl_o.cin_sel = CIN_ONE;
            end
            OP_SBC: begin
                ctl_o.cls     = CLS_SUB;
                ctl_o.inv_b   = 1'b1;
                ctl_o.cin_sel = CIN_FLAG;
            end
            OP_RSC: begin
                ctl_o.cls     = CLS_SUB;
                ctl_o.swap    = 1'b1;
                ctl_o.inv_b   = 1'b1;
                ctl_o.cin_sel = CIN_FLAG;
            end
            OP_CMP: begin
                ctl_o.cls          = CLS_SUB;
                ctl_o.inv_b        = 1'b1;
                ctl_o.cin_sel      = CIN_ONE;
                ctl_o.writes_dest  = 1'b0;
                ctl_o.forces_flags = 1'b1;
            end
            default: ctl_o.lfn = LF_AND;
        endcase
    end
endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              swap_i,
    input  logic              inv_i,
    input  cin_sel_e          cin_sel_i,
    input  logic              c_flag_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x, y_raw, y;
    logic              cin;
    logic [DATA_W:0]   wide;

    always_comb begin
        x     = swap_i ? b_i : a_i;
        y_raw = swap_i ? a_i : b_i;
        y     = inv_i ? ~y_raw : y_raw;
        case (cin_sel_i)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = c_flag_i;
            default:  cin = 1'b0;
        endcase
        wide   = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        sum_o  = wide[MSB:0];
        cout_o = wide[DATA_W];
        ovf_o  = (x[MSB] == y[MSB]) && (sum_o[MSB] != x[MSB]);
    end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic_fn_e         fn_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        case (fn_i)
            LF_AND:  res_o = a_i & b_i;
            LF_EOR:  res_o = a_i ^ b_i;
            LF_ORR:  res_o = a_i | b_i;
            LF_PASS: res_o = b_i;
            LF_BIC:  res_o = a_i & ~b_i;
            LF_NOT:  res_o = ~b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              update_i,
    input  op_class_e         cls_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              cout_i,
    input  logic              ovf_i,
    input  logic              sh_carry_i,
    input  nzcv_t             flags_i,
    output nzcv_t             flags_o
);
    always_comb begin
        if (!update_i) begin
            flags_o = flags_i;
        end else begin
            flags_o.n = res_i[DATA_W-1];
            flags_o.z = ~|res_i;
            if (cls_i == CLS_LOGIC) begin
                flags_o.c = sh_carry_i;
                flags_o.v = flags_i.v;
            end else begin
                flags_o.c = cout_i;
                flags_o.v = ovf_i;
            end
        end
    end
endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              sh_carry_i,
    input  logic [3:0]        opcode_i,
    input  logic              set_flags_i,
    input  logic              dest_pc_i,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o,
    output logic              wr_dest_o,
    output logic              restore_o
);
    alu_ctl_t          ctl;
    logic [DATA_W-1:0] arith_res, logic_res, res_d;
    logic              arith_cout, arith_ovf;
    logic              set_eff, restore_d, update_d;
    nzcv_t             flags_cur, flags_d;

    logic [DATA_W-1:0] result_q;
    nzcv_t             flags_q;
    logic              wr_q, restore_q, live_q;

    assign flags_cur = nzcv_t'(flags_i);

    dp_alu_decode u_decode (
        .opcode_i (opcode_i),
        .ctl_o    (ctl)
    );

    dp_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i       (op_a_i),
        .b_i       (op_b_i),
        .swap_i    (ctl.swap),
        .inv_i     (ctl.inv_b),
        .cin_sel_i (ctl.cin_sel),
        .c_flag_i  (flags_cur.c),
        .sum_o     (arith_res),
        .cout_o    (arith_cout),
        .ovf_o     (arith_ovf)
    );

    dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i   (op_a_i),
        .b_i   (op_b_i),
        .fn_i  (ctl.lfn),
        .res_o (logic_res)
    );

    assign res_d     = (ctl.cls == CLS_LOGIC) ? logic_res : arith_res;
    assign set_eff   = set_flags_i | ctl.forces_flags;
    assign restore_d = set_eff & dest_pc_i & mode_owns_saved(mode_i);
    assign update_d  = set_eff & ~restore_d;

    dp_alu_flags #(.DATA_W(DATA_W)) u_flags (
        .update_i   (update_d),
        .cls_i      (ctl.cls),
        .res_i      (res_d),
        .cout_i     (arith_cout),
        .ovf_i      (arith_ovf),
        .sh_carry_i (sh_carry_i),
        .flags_i    (flags_cur),
        .flags_o    (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q  <= '0;
            flags_q   <= '0;
            wr_q      <= 1'b0;
            restore_q <= 1'b0;
            live_q    <= 1'b0;
        end else begin
            result_q  <= res_d;
            flags_q   <= flags_d;
            wr_q      <= ctl.writes_dest;
            restore_q <= restore_d;
            live_q    <= 1'b1;
        end
    end

    assign result_o  = result_q;
    assign flags_o   = flags_q;
    assign wr_dest_o = wr_q;
    assign restore_o = restore_q;

    // R6: compare and test codes never write the destination
    p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (live_q && ($past(opcode_i) >= 4'd8) && ($past(opcode_i) <= 4'd11)) |-> !wr_dest_o);

    // R7: flags pass through when no update was requested
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(set_flags_i) && wr_dest_o) |-> (flags_o == $past(flags_i)));

    // R8: a restore request leaves the flags untouched
    p_restore_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (live_q && restore_o) |-> (flags_o == $past(flags_i)));

    // R9: restore only in a mode that owns a saved status register
    p_restore_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (live_q && restore_o) |-> (($past(mode_i) != MODE_USR) && ($past(mode_i) != MODE_SYS)));

    // R5: Z tracks a zero result whenever flags were requested
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (live_q && !restore_o && $past(set_flags_i)) |-> (flags_o[2] == (result_o == '0)));

    // R4: logical operations keep V
    p_logic_keeps_v_r4: assert property (@(posedge clk) disable iff (rst)
        (live_q && code_is_logical($past(opcode_i))) |-> (flags_o[0] == $past(flags_i[0])));

    // R10: outputs are quiet in the cycle after a reset cycle
    p_reset_clear_r10: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (result_o == '0 && flags_o == 4'h0 && !wr_dest_o && !restore_o));
endmodule

// File: tb/dp_alu_core_tb.sv
`timescale 1ns/1ps
module dp_alu_core_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_a, op_b;
    logic        shc, setf, dpc;
    logic [3:0]  opc, fl_in;
    logic [4:0]  mode;
    logic [31:0] res;
    logic [3:0]  fl_out;
    logic        wr, rs;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dp_alu_core u_dut (
        .clk(clk), .rst(rst), .op_a_i(op_a), .op_b_i(op_b), .sh_carry_i(shc),
        .opcode_i(opc), .set_flags_i(setf), .dest_pc_i(dpc), .mode_i(mode),
        .flags_i(fl_in), .result_o(res), .flags_o(fl_out), .wr_dest_o(wr),
        .restore_o(rs)
    );

    function automatic void model(
        input  logic [31:0] a, input logic [31:0] b, input logic sc,
        input  logic [3:0] op, input logic s, input logic pc,
        input  logic [4:0] m, input logic [3:0] f,
        output logic [31:0] r, output logic [3:0] fo, output logic w,
        output logic rq, output string tag);
        logic [32:0] t;
        logic cf, c, v, lg, se;
        cf = f[1]; c = 1'b0; v = 1'b0; lg = 1'b0; r = '0;
        case (op)
            4'd0, 4'd8: begin r = a & b; lg = 1'b1; end
            4'd1, 4'd9: begin r = a ^ b; lg = 1'b1; end
            4'd12: begin r = a | b; lg = 1'b1; end
            4'd13: begin r = b; lg = 1'b1; end
            4'd14: begin r = a & ~b; lg = 1'b1; end
            4'd15: begin r = ~b; lg = 1'b1; end
            4'd4, 4'd11: begin
                t = {1'b0, a} + {1'b0, b}; r = t[31:0]; c = t[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'd5: begin
                t = {1'b0, a} + {1'b0, b} + {32'b0, cf}; r = t[31:0]; c = t[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'd2, 4'd10: begin
                r = a - b; c = (a >= b);
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            4'd3: begin
                r = b - a; c = (b >= a);
                v = (a[31] != b[31]) && (r[31] != b[31]);
            end
            4'd6: begin
                r = a - b - {31'b0, !cf}; c = ({1'b0, a} >= ({1'b0, b} + {32'b0, !cf}));
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            default: begin
                r = b - a - {31'b0, !cf}; c = ({1'b0, b} >= ({1'b0, a} + {32'b0, !cf}));
                v = (a[31] != b[31]) && (r[31] != b[31]);
            end
        endcase
        w  = !(op >= 4'd8 && op <= 4'd11);
        se = s || !w;
        rq = se && pc && (m != 5'b10000) && (m != 5'b11111);
        if (!se || rq) fo = f;
        else fo = {r[31], (r == 32'd0), lg ? sc : c, lg ? f[0] : v};
        if (rq) tag = "R8";
        else if (!w) tag = "R6";
        else if (!s) tag = "R7";
        else if (lg) tag = "R4";
        else if (op == 4'd4 || op == 4'd5) tag = "R2";
        else tag = "R3";
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic sc,
                         input logic [3:0] op, input logic s, input logic pc,
                         input logic [4:0] m, input logic [3:0] f, input string force_tag);
        logic [31:0] er; logic [3:0] ef; logic ew, erq; string tg;
        @(negedge clk);
        op_a = a; op_b = b; shc = sc; opc = op; setf = s; dpc = pc; mode = m; fl_in = f;
        model(a, b, sc, op, s, pc, m, f, er, ef, ew, erq, tg);
        if (force_tag != "") tg = force_tag;
        @(posedge clk); #1;
        n_vec++;
        if (res !== er || fl_out !== ef || wr !== ew || rs !== erq) begin
            n_bad++;
            $display("FAIL %s op=%0d res=%h/%h flags=%h/%h wr=%b/%b restore=%b/%b",
                     tg, op, res, er, fl_out, ef, wr, ew, rs, erq);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb;
        void'($urandom(32'h1234_5eed));
        rst = 1'b1;
        op_a = 32'hFFFF_FFFF; op_b = 32'h1; shc = 1'b1; opc = 4'd4;
        setf = 1'b1; dpc = 1'b1; mode = 5'b10011; fl_in = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        n_vec++;
        if (res !== 32'd0 || fl_out !== 4'h0 || wr !== 1'b0 || rs !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset outputs res=%h flags=%h wr=%b rs=%b expected all zero",
                     res, fl_out, wr, rs);
        end
        rst = 1'b0;

        // R1: each logical function with fixed operands
        apply(32'hF0F0_1234, 32'h0FF0_00FF, 1'b0, 4'd0,  1'b0, 1'b0, 5'b10000, 4'h0, "R1");
        apply(32'hF0F0_1234, 32'h0FF0_00FF, 1'b0, 4'd1,  1'b0, 1'b0, 5'b10000, 4'h0, "R1");
        apply(32'hF0F0_1234, 32'h0FF0_00FF, 1'b0, 4'd12, 1'b0, 1'b0, 5'b10000, 4'h0, "R1");
        apply(32'hF0F0_1234, 32'h0FF0_00FF, 1'b0, 4'd13, 1'b0, 1'b0, 5'b10000, 4'h0, "R1");
        apply(32'hF0F0_1234, 32'h0FF0_00FF, 1'b0, 4'd14, 1'b0, 1'b0, 5'b10000, 4'h0, "R1");
        apply(32'hF0F0_1234, 32'h0FF0_00FF, 1'b0, 4'd15, 1'b0, 1'b0, 5'b10000, 4'h0, "R1");
        // R2: carry and overflow corners
        apply(32'hFFFF_FFFF, 32'h1, 1'b0, 4'd4, 1'b1, 1'b0, 5'b10000, 4'h0, "R2");
        apply(32'h7FFF_FFFF, 32'h1, 1'b0, 4'd4, 1'b1, 1'b0, 5'b10000, 4'h0, "R2");
        apply(32'h7FFF_FFFF, 32'h0, 1'b0, 4'd5, 1'b1, 1'b0, 5'b10000, 4'h2, "R2");
        // R3: borrow corners including SBC/RSC carry-in
        apply(32'h5, 32'h5, 1'b0, 4'd2, 1'b1, 1'b0, 5'b10000, 4'h0, "R3");
        apply(32'h4, 32'h5, 1'b0, 4'd2, 1'b1, 1'b0, 5'b10000, 4'h0, "R3");
        apply(32'h5, 32'h5, 1'b0, 4'd6, 1'b1, 1'b0, 5'b10000, 4'h0, "R3");
        apply(32'h8000_0000, 32'h1, 1'b0, 4'd2, 1'b1, 1'b0, 5'b10000, 4'h0, "R3");
        apply(32'h3, 32'h9, 1'b0, 4'd7, 1'b1, 1'b0, 5'b10000, 4'h2, "R3");
        // R5: zero result sets Z
        apply(32'h0000_00FF, 32'hFF00_0000, 1'b1, 4'd0, 1'b1, 1'b0, 5'b10000, 4'h1, "R5");
        // R6: compare with set-flags low
        apply(32'h8, 32'h8, 1'b0, 4'd10, 1'b0, 1'b0, 5'b10000, 4'h0, "R6");
        // R8: restore in a privileged mode, incl. compare
        apply(32'h1, 32'h2, 1'b0, 4'd4, 1'b1, 1'b1, 5'b10011, 4'h5, "R8");
        apply(32'h1, 32'h1, 1'b0, 4'd10, 1'b0, 1'b1, 5'b10010, 4'h9, "R8");
        // R9: user and system modes update flags
        apply(32'h1, 32'h1, 1'b0, 4'd2, 1'b1, 1'b1, 5'b10000, 4'h0, "R9");
        apply(32'h1, 32'h1, 1'b0, 4'd2, 1'b1, 1'b1, 5'b11111, 4'h0, "R9");
        // R11: every non-compare op writes with set-flags low
        for (int k = 0; k < 16; k++) begin
            if (k < 8 || k > 11)
                apply(32'h1357_9BDF, 32'h2468_ACE0, 1'b1, k[3:0], 1'b0, 1'b0, 5'b10011, 4'hA, "R11");
        end
        // R10: output holds until the next rising edge
        @(negedge clk);
        pa = res;
        op_a = 32'h1; op_b = 32'h1; opc = 4'd4; setf = 1'b0; dpc = 1'b0;
        #1;
        n_vec++;
        if (res !== pa) begin
            n_bad++;
            $display("FAIL R10 output changed before edge res=%h expected %h", res, pa);
        end
        @(posedge clk); #1;
        n_vec++;
        if (res !== 32'h2) begin
            n_bad++;
            $display("FAIL R10 output after edge res=%h expected %h", res, 32'h2);
        end

        // Random vectors
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] m;
            case ($urandom % 4)
                0: m = 5'b10000;
                1: m = 5'b11111;
                2: m = 5'b10011;
                default: m = 5'($urandom);
            endcase
            case ($urandom % 5)
                0: pa = 32'h0;
                1: pa = 32'h7FFF_FFFF;
                2: pa = 32'h8000_0000;
                default: pa = $urandom;
            endcase
            case ($urandom % 5)
                0: pb = 32'hFFFF_FFFF;
                1: pb = pa;
                default: pb = $urandom;
            endcase
            apply(pa, pb, 1'($urandom), 4'($urandom), 1'($urandom),
                  (($urandom % 4) == 0), m, 4'($urandom), "");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule